// File: doc/BRIEF.md
# Forced Debug-Halt Timeout Unit

This unit lets a debug halt succeed on a core whose load/store or instruction-fetch bus has hung. When a halt is requested, the core normally drains its outstanding bus traffic, reports that it is quiesced, and then enters the debug-halt state. If that traffic never completes, the core would never halt. When the unit is enabled and traffic is outstanding while a halt is pending, it counts core clocks. When the count reaches a power-of-two limit, it cuts off the outstanding transactions and forces halt entry.

A small state machine tracks the halt. `ST_RUN` is normal execution. `ST_DRAIN` is the wait for quiescence after a halt request, during which the timeout counter runs. `ST_HALT` is the debug-halt state. The transitions are:

- `req_accept`: `ST_RUN` to `ST_DRAIN` when a halt is requested.
- `req_drop`: `ST_DRAIN` to `ST_RUN` when the request is withdrawn before entry.
- `graceful_entry`: `ST_DRAIN` to `ST_HALT` when the core reports quiescence.
- `forced_entry`: `ST_DRAIN` to `ST_HALT` when the timeout expires.
- `resume_exit`: `ST_HALT` to `ST_RUN` on a resume.

Two registers on a simple CSR port configure the unit and report its results. The configuration register is at address 0x7CE. The sticky termination status register is at address 0x7CF.

Top module: `fdh_timeout_unit`

## Requirements
- R1: After reset, `dbg_halted`, `halt_enter`, `force_halt`, `lsu_term` and `ifu_term` are 0, and both registers read 0.
- R2: The configuration register at 0x7CE holds the enable in bit 0 and a 5-bit exponent E in bits 5:1, with E up to 31. Bits 31:6 read 0, and any address other than 0x7CE and 0x7CF reads 0.
- R3: With the enable set and any transaction outstanding in the first `ST_DRAIN` cycle, `force_halt` and `halt_enter` rise together in `ST_DRAIN` cycle 2^E, counting from 0, if quiescence has not been reported by then.
- R4: Quiescence reported in a `ST_DRAIN` cycle raises `halt_enter` with `force_halt` low and both terminate outputs low. This also holds when quiescence arrives in the same cycle as the timeout.
- R5: In the cycle `force_halt` is high, `lsu_term` and `ifu_term` are high exactly for the units that have a transaction outstanding in that cycle.
- R6: With the enable clear, `force_halt` never rises, and halt entry waits for quiescence.
- R7: The status register at 0x7CF holds a load/store termination flag in bit 1 and a fetch termination flag in bit 0. A flag is set when its unit is terminated, is left unchanged by a graceful entry, and holds until a CSR write replaces it.
- R8: The counter restarts from zero on each new halt, so the timeout cycle is the same for every halt.
- R9: Once counting has started, it continues while `ST_DRAIN` lasts, even after all outstanding transactions have finished.
- R10: `dbg_halted` rises the cycle after `halt_enter`, stays high until `dbg_resume`, and falls the cycle after `dbg_resume`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address, used for both reads and writes |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_addr`, combinational |
| dbg_halt_req | input | 1 | A debug halt is requested, held high until entry |
| dbg_resume | input | 1 | Leave the debug-halt state |
| lsu_pend | input | 1 | A load/store bus transaction is outstanding |
| ifu_pend | input | 1 | A fetch bus transaction is outstanding |
| core_quiesced | input | 1 | The core has drained and may halt normally |
| lsu_term | output | 1 | Terminate outstanding load/store transactions |
| ifu_term | output | 1 | Terminate outstanding fetch transactions |
| force_halt | output | 1 | Halt entry is being forced by timeout |
| halt_enter | output | 1 | Halt entry happens in this cycle, forced or graceful |
| dbg_halted | output | 1 | In the debug-halt state |

## Verification
The request is taken at the first clock edge after `dbg_halt_req` rises, and the first `ST_DRAIN` cycle, numbered 0, follows that edge. The outputs `halt_enter`, `force_halt` and the terminate signals are combinational within `ST_DRAIN`, so the bench drives the pending and quiescence inputs at each falling edge, waits a short settle time, and compares entry against the expected cycle 2^E or the quiescence cycle. `dbg_halted` and the status flags are registered, so they are checked one falling edge after entry. CSR reads are combinational and are checked after the same settle delay. The random cases draw the exponent, enable, pending pattern, the cycle at which traffic drains and the quiescence cycle from a fixed seed. Directed cases cover the tie between quiescence and timeout, the disabled unit and the clearing of the status flags.

// File: rtl/fdh_pkg.sv
package fdh_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HALT  = 2'd2
    } fdh_state_e;

    localparam logic [11:0] FDH_CFG_ADDR = 12'h7CE;
    localparam logic [11:0] FDH_STS_ADDR = 12'h7CF;
endpackage

// File: rtl/fdh_cfg_regs.sv
module fdh_cfg_regs #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter int          EXP_W    = 5,
    parameter logic [11:0] CFG_ADDR = fdh_pkg::FDH_CFG_ADDR,
    parameter logic [11:0] STS_ADDR = fdh_pkg::FDH_STS_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              set_lsu,
    input  logic              set_ifu,
    output logic              cfg_en,
    output logic [EXP_W-1:0]  cfg_exp,
    output logic [DATA_W-1:0] csr_rdata
);
    localparam int CFG_BITS = EXP_W + 1;

    logic sts_lsu_q, sts_ifu_q;
    logic wr_cfg, wr_sts;

    assign wr_cfg = csr_we && (csr_addr == CFG_ADDR[ADDR_W-1:0]);
    assign wr_sts = csr_we && (csr_addr == STS_ADDR[ADDR_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en  <= 1'b0;
            cfg_exp <= '0;
        end else if (wr_cfg) begin
            cfg_en  <= csr_wdata[0];
            cfg_exp <= csr_wdata[CFG_BITS-1:1];
        end
    end

    // Hardware set takes priority over a same-cycle software write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_lsu_q <= 1'b0;
            sts_ifu_q <= 1'b0;
        end else begin
            if (set_lsu)     sts_lsu_q <= 1'b1;
            else if (wr_sts) sts_lsu_q <= csr_wdata[1];
            if (set_ifu)     sts_ifu_q <= 1'b1;
            else if (wr_sts) sts_ifu_q <= csr_wdata[0];
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (csr_addr == CFG_ADDR[ADDR_W-1:0])
            csr_rdata[CFG_BITS-1:0] = {cfg_exp, cfg_en};
        else if (csr_addr == STS_ADDR[ADDR_W-1:0])
            csr_rdata[1:0] = {sts_lsu_q, sts_ifu_q};
    end

    // R7
    sts_lsu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_lsu_q && !wr_sts) |=> sts_lsu_q);
    // R7
    sts_ifu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ifu_q && !wr_sts) |=> sts_ifu_q);
endmodule

// File: rtl/fdh_timeout_ctr.sv
module fdh_timeout_ctr #(
    parameter int CNT_W = 32,
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             clear,
    input  logic             pend_any,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             reached
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             step;

    assign limit = ONE << exp_sel;
    assign step  = run && ((cnt_q != '0) || pend_any) && (cnt_q != '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!en || clear)   cnt_q <= '0;
        else if (step)           cnt_q <= cnt_q + ONE;
    end

    assign reached = en && run && (limit != '0) && (cnt_q >= limit);

    // R6
    ctr_idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
    // R8
    ctr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clear) |=> (cnt_q == '0));
endmodule

// File: rtl/fdh_timeout_unit.sv
module fdh_timeout_unit #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int EXP_W  = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              dbg_halt_req,
    input  logic              dbg_resume,
    input  logic              lsu_pend,
    input  logic              ifu_pend,
    input  logic              core_quiesced,
    output logic              lsu_term,
    output logic              ifu_term,
    output logic              force_halt,
    output logic              halt_enter,
    output logic              dbg_halted
);
    import fdh_pkg::*;

    fdh_state_e       state_q, state_d;
    logic             cfg_en;
    logic [EXP_W-1:0] cfg_exp;
    logic             reached;
    logic             in_drain, ctr_clear;

    assign in_drain  = (state_q == ST_DRAIN);
    assign ctr_clear = (state_q == ST_RUN) || ((state_q == ST_HALT) && dbg_resume);

    fdh_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EXP_W  (EXP_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .set_lsu   (lsu_term),
        .set_ifu   (ifu_term),
        .cfg_en    (cfg_en),
        .cfg_exp   (cfg_exp),
        .csr_rdata (csr_rdata)
    );

    fdh_timeout_ctr #(
        .CNT_W (CNT_W),
        .EXP_W (EXP_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .run      (in_drain),
        .clear    (ctr_clear),
        .pend_any (lsu_pend || ifu_pend),
        .exp_sel  (cfg_exp),
        .reached  (reached)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (dbg_halt_req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (core_quiesced || reached) state_d = ST_HALT;
                else if (!dbg_halt_req)       state_d = ST_RUN;
            end
            ST_HALT:  if (dbg_resume) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        halt_enter = 1'b0;
        force_halt = 1'b0;
        lsu_term   = 1'b0;
        ifu_term   = 1'b0;
        dbg_halted = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_DRAIN: begin
                halt_enter = core_quiesced || reached;
                force_halt = !core_quiesced && reached;
                lsu_term   = force_halt && lsu_pend;
                ifu_term   = force_halt && ifu_pend;
            end
            ST_HALT:  dbg_halted = 1'b1;
            default:  ;
        endcase
    end

    // R6
    force_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_halt |-> cfg_en);
    // R5
    term_only_on_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsu_term || ifu_term) |-> force_halt);
    // R10
    entry_then_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |=> dbg_halted);
    // R10
    halted_until_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halted && !dbg_resume) |=> dbg_halted);
    // R4
    quiesce_not_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_drain && core_quiesced) |-> (halt_enter && !force_halt));
endmodule

// File: tb/fdh_timeout_unit_tb.sv
module fdh_timeout_unit_tb;
    localparam logic [11:0] CFG = 12'h7CE;
    localparam logic [11:0] STS = 12'h7CF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = 12'h0;
    logic [31:0] csr_wdata = 32'h0;
    logic [31:0] csr_rdata;
    logic        dbg_halt_req = 1'b0, dbg_resume = 1'b0;
    logic        lsu_pend = 1'b0, ifu_pend = 1'b0, core_quiesced = 1'b0;
    logic        lsu_term, ifu_term, force_halt, halt_enter, dbg_halted;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_sts = 2'b00;

    always #10 clk = ~clk;

    fdh_timeout_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .dbg_halt_req(dbg_halt_req), .dbg_resume(dbg_resume),
        .lsu_pend(lsu_pend), .ifu_pend(ifu_pend), .core_quiesced(core_quiesced),
        .lsu_term(lsu_term), .ifu_term(ifu_term), .force_halt(force_halt),
        .halt_enter(halt_enter), .dbg_halted(dbg_halted)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int expected_entry(bit en, bit lp, bit ip, int t, int q);
        if (en && (lp || ip) && ((1 << t) < q)) return 1 << t;
        return q;
    endfunction

    task automatic csr_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(logic [11:0] a, output logic [31:0] d);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic run_case(string tag, int t, bit en, bit lp, bit ip, int q, int drop);
        logic [31:0] rd;
        int   ent, want;
        bit   f, lt, it, forced, exp_lt, exp_it;
        csr_write(CFG, {26'h0, t[4:0], en});
        csr_read(CFG, rd);
        check({tag, " R2 cfg readback"}, rd, {26'h0, t[4:0], en});
        want   = expected_entry(en, lp, ip, t, q);
        forced = en && (lp || ip) && ((1 << t) < q);
        exp_lt = forced && lp && ((1 << t) < drop);
        exp_it = forced && ip && ((1 << t) < drop);
        lsu_pend = lp; ifu_pend = ip; dbg_halt_req = 1'b1;
        ent = -1; f = 0; lt = 0; it = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            core_quiesced = (c >= q);
            if (c >= drop) begin lsu_pend = 1'b0; ifu_pend = 1'b0; end
            #1;
            if (halt_enter) begin
                ent = c; f = force_halt; lt = lsu_term; it = ifu_term;
                break;
            end
            if (force_halt || lsu_term || ifu_term)
                check({tag, " R3 no early force"}, 1, 0);
        end
        // R3 R4 R6 R9: entry cycle and kind
        check({tag, " R3/R4 entry cycle"}, ent, want);
        check({tag, " R4/R6 forced flag"}, {31'h0, f}, {31'h0, forced});
        // R5
        check({tag, " R5 term lines"}, {30'h0, lt, it}, {30'h0, exp_lt, exp_it});
        exp_sts = exp_sts | {exp_lt, exp_it};
        @(negedge clk);
        check({tag, " R10 halted after entry"}, {31'h0, dbg_halted}, 32'h1);
        csr_read(STS, rd);
        // R7
        check({tag, " R7 status"}, rd, {30'h0, exp_sts});
        dbg_halt_req = 1'b0; core_quiesced = 1'b0;
        lsu_pend = 1'b0; ifu_pend = 1'b0; dbg_resume = 1'b1;
        @(negedge clk);
        #1 check({tag, " R10 exit on resume"}, {31'h0, dbg_halted}, 32'h0);
        dbg_resume = 1'b0;
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int seed;
        seed = 32'h1F0D;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        #1 check("R1 halted", {31'h0, dbg_halted}, 0);
        check("R1 outputs", {28'h0, halt_enter, force_halt, lsu_term, ifu_term}, 0);
        csr_read(CFG, rd); check("R1 cfg reset", rd, 0);
        csr_read(STS, rd); check("R1 sts reset", rd, 0);
        // R2: high bits ignored, max exponent, foreign address
        csr_write(CFG, 32'hFFFF_FFFF);
        csr_read(CFG, rd); check("R2 bits 31:6 zero, exp 31", rd, 32'h3F);
        csr_read(12'h7CD, rd); check("R2 other address", rd, 0);

        // R3 R5 smallest and larger thresholds
        run_case("d0", 0, 1, 1, 1, 999, 999);
        run_case("d1", 5, 1, 1, 0, 999, 999);
        // R8: same again, counter restarted
        run_case("d2", 5, 1, 0, 1, 999, 999);
        // R4 tie: quiescence in the timeout cycle
        run_case("d3", 3, 1, 1, 1, 8, 999);
        // R6 disabled unit
        run_case("d4", 0, 0, 1, 1, 100, 999);
        // R9 traffic drains after count starts, no quiescence
        run_case("d5", 4, 1, 1, 1, 999, 3);
        // R7 clear by write, then graceful entry leaves it clear
        csr_write(STS, 32'h0); exp_sts = 2'b00;
        csr_read(STS, rd); check("R7 cleared by write", rd, 0);
        run_case("d6", 2, 1, 1, 1, 2, 999);
        // R7 software can set a flag
        csr_write(STS, 32'h2); exp_sts = 2'b10;
        csr_read(STS, rd); check("R7 written flag", rd, 32'h2);

        for (int i = 0; i < 40; i++) begin
            int t, q, drop;
            bit en, lp, ip;
            t    = $urandom_range(5, 0);
            en   = ($urandom_range(3, 0) != 0);
            lp   = $urandom_range(1, 0);
            ip   = $urandom_range(1, 0);
            q    = ($urandom_range(2, 0) == 0) ? 999 : $urandom_range(70, 1);
            drop = ($urandom_range(1, 0) == 0) ? 999 : $urandom_range(40, 1);
            if (!(en && (lp || ip)) && q == 999) q = 60;
            run_case($sformatf("r%0d", i), t, en, lp, ip, q, drop);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule